// File: doc/BRIEF.md
# Nine-bit three-wire panel SPI engine

This block is a serial master for the command port of a display panel. A host hands it one request at a time: a command byte, a count of parameter bytes to write after it, and a count of bytes to read back. The engine selects the panel, shifts out the command as a 9-bit word whose leading bit marks it as a command, then sends each parameter byte as a 9-bit word whose leading bit marks it as data. If bytes are to be read, it keeps clocking with MOSI held low and collects the returned bits from MISO. It then deselects the panel and pulses `done`.

Parameter bytes arrive on a valid/ready stream and are pulled one word at a time. If the stream has nothing to offer, the engine parks with the serial clock low and chip select still asserted. Returned bytes leave on a valid-only stream, one pulse per byte. The panel's read protocol is not uniform. A one-byte read returns eight bits straight after the command. A read of two or more bytes returns an extra turnaround bit before the first byte, and the engine discards it.

The bus uses clock-idle-low, sample-on-rising-edge timing. Each SCK half period lasts `HALF_DIV` system clocks. Requests are accepted only while the engine is idle.

Top module: `panel_cmd_spi9`

## Requirements
- R1: The bus follows mode 0 timing. SCK is low whenever `spi_csn` is high. MOSI changes only while SCK is low. MISO is sampled on the rising SCK edge, and the serving device changes it on falling edges.
- R2: Every transfer begins with a 9-bit command word sent MSB first: a 0 flag bit, then `req_cmd` bit 7 down to bit 0.
- R3: Each of the `req_wcnt` parameter bytes is taken from the write stream in arrival order. It is sent as a 9-bit word: a 1 flag bit, then the byte MSB first, so 0x70 appears as 9'h170. While the stream is not valid, the engine holds SCK low and keeps the panel selected.
- R4: When `req_rcnt` is 1, exactly 8 bits are clocked in after the last written word. They form the read byte MSB first.
- R5: When `req_rcnt` is greater than 1, the first byte takes 9 SCK cycles. The first of those bits is discarded and the last 8 form the byte MSB first. Each following byte takes 8 SCK cycles.
- R6: MOSI is low on every SCK cycle of the read phase.
- R7: `spi_csn` is low from before the first command bit until after the last bit of the transfer. It stays high for at least 2*HALF_DIV clock cycles between transfers.
- R8: `req_ready` is high only while the engine is idle with the panel deselected. A request made while `req_ready` is low is ignored and produces no bus activity.
- R9: `done` is a single-cycle pulse, issued once per transfer as chip select is released. `rd_valid` pulses once for each read byte, carrying it on `rd_data`.
- R10: A request with zero write and zero read counts produces exactly 9 SCK rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_cmd | input | 8 | Command byte |
| req_wcnt | input | CNT_W | Number of parameter bytes to write |
| req_rcnt | input | CNT_W | Number of bytes to read |
| wr_valid | input | 1 | Parameter byte available |
| wr_ready | output | 1 | Engine takes the parameter byte this cycle |
| wr_data | input | 8 | Parameter byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transfer finished pulse |
| spi_csn | output | 1 | Panel select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to panel |
| spi_miso | input | 1 | Serial data from panel |

## Verification
The bench runs the following patterns:
- A bare command, which separates the fixed 9-bit command frame from any parameter or read handling.
- Single and multiple parameter writes, one of them with a stream stall in the middle. These show that flag bits, byte order and the stall hold are all right.
- A one-byte read, compared against multi-byte reads whose discarded turnaround bit is set to 1 in one case and 0 in the other. A wrong bit count or a kept turnaround bit corrupts the returned bytes in a visible way.
- A combined write-then-read.
- A request poked while the engine is busy, which must leave no trace on the bus.

// File: rtl/pspi_pkg.sv
package pspi_pkg;

    localparam int WORD_BITS = 9;
    localparam int BYTE_BITS = 8;

    typedef logic [WORD_BITS-1:0]             word_t;
    typedef logic [$clog2(WORD_BITS+1)-1:0]   bitcnt_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOW,
        S_HIGH,
        S_FEED,
        S_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        P_CMD,
        P_PARAM,
        P_READ
    } phase_t;

    typedef struct packed {
        word_t   bits;
        bitcnt_t len;
    } word_load_t;

    function automatic word_load_t cmd_word(input logic [BYTE_BITS-1:0] c);
        word_load_t w;
        w.bits = {1'b0, c};
        w.len  = bitcnt_t'(WORD_BITS);
        return w;
    endfunction

    function automatic word_load_t param_word(input logic [BYTE_BITS-1:0] d);
        word_load_t w;
        w.bits = {1'b1, d};
        w.len  = bitcnt_t'(WORD_BITS);
        return w;
    endfunction

    function automatic word_load_t read_word(input logic lead_bit);
        word_load_t w;
        w.bits = '0;
        w.len  = lead_bit ? bitcnt_t'(WORD_BITS) : bitcnt_t'(BYTE_BITS);
        return w;
    endfunction

endpackage

// File: rtl/pspi_tick.sv
module pspi_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pspi_shift.sv
module pspi_shift
    import pspi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  word_load_t load_word,
    input  logic       advance,
    input  logic       sample,
    input  logic       miso,
    output logic       mosi,
    output logic       last,
    output logic [BYTE_BITS-1:0] rx_byte
);
    word_t                 sh;
    bitcnt_t               left;
    logic [BYTE_BITS-1:0]  rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            left <= '0;
            rx   <= '0;
        end else begin
            if (load) begin
                sh   <= load_word.bits;
                left <= load_word.len;
            end else if (advance) begin
                sh   <= {sh[WORD_BITS-2:0], 1'b0};
                left <= left - 1'b1;
            end
            if (sample)
                rx <= {rx[BYTE_BITS-2:0], miso};
        end
    end

    assign mosi    = sh[WORD_BITS-1];
    assign last    = (left == bitcnt_t'(1));
    assign rx_byte = rx;

    // R5: only 8- or 9-bit words are ever framed
    assert_word_len_R5: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_word.len == bitcnt_t'(BYTE_BITS) || load_word.len == bitcnt_t'(WORD_BITS)));
endmodule

// File: rtl/pspi_seq.sv
module pspi_seq
    import pspi_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [7:0]            req_cmd,
    input  logic [CNT_W-1:0]      req_wcnt,
    input  logic [CNT_W-1:0]      req_rcnt,
    input  logic                  wr_valid,
    input  logic [7:0]            wr_data,
    input  logic                  tick,
    input  logic                  last,
    input  logic [BYTE_BITS-1:0]  rx_byte,
    output logic                  req_ready,
    output logic                  wr_ready,
    output logic                  run,
    output logic                  load,
    output word_load_t            load_word,
    output logic                  advance,
    output logic                  sample,
    output logic                  csn,
    output logic                  sck,
    output logic                  in_read,
    output logic                  rd_valid,
    output logic [BYTE_BITS-1:0]  rd_data,
    output logic                  done
);
    seq_state_t        state;
    phase_t            phase;
    logic [CNT_W-1:0]  wleft;
    logic [CNT_W-1:0]  rleft;
    logic              multi;
    logic              gap2;

    logic word_end;

    assign req_ready = (state == S_IDLE);
    assign wr_ready  = (state == S_FEED);
    assign run       = (state == S_LOW) || (state == S_HIGH) || (state == S_GAP);
    assign word_end  = (state == S_HIGH) && tick && last;
    assign advance   = (state == S_HIGH) && tick && !last;
    assign sample    = (state == S_LOW) && tick;
    assign in_read   = (phase == P_READ);

    always_comb begin
        load      = 1'b0;
        load_word = param_word(wr_data);
        case (state)
            S_IDLE: if (req_valid) begin
                load      = 1'b1;
                load_word = cmd_word(req_cmd);
            end
            S_FEED: if (wr_valid) begin
                load      = 1'b1;
                load_word = param_word(wr_data);
            end
            S_HIGH: if (word_end) begin
                if (phase != P_READ && wleft == '0 && rleft != '0) begin
                    load      = 1'b1;
                    load_word = read_word(multi);
                end else if (phase == P_READ && rleft > CNT_W'(1)) begin
                    load      = 1'b1;
                    load_word = read_word(1'b0);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            phase    <= P_CMD;
            wleft    <= '0;
            rleft    <= '0;
            multi    <= 1'b0;
            gap2     <= 1'b0;
            csn      <= 1'b1;
            sck      <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            done     <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            case (state)
                S_IDLE: if (req_valid) begin
                    wleft <= req_wcnt;
                    rleft <= req_rcnt;
                    multi <= (req_rcnt > CNT_W'(1));
                    phase <= P_CMD;
                    csn   <= 1'b0;
                    state <= S_LOW;
                end
                S_LOW: if (tick) begin
                    sck   <= 1'b1;
                    state <= S_HIGH;
                end
                S_HIGH: if (tick) begin
                    sck <= 1'b0;
                    if (!last) begin
                        state <= S_LOW;
                    end else if (phase != P_READ) begin
                        if (wleft != '0) begin
                            state <= S_FEED;
                        end else if (rleft != '0) begin
                            phase <= P_READ;
                            state <= S_LOW;
                        end else begin
                            csn   <= 1'b1;
                            done  <= 1'b1;
                            gap2  <= 1'b0;
                            state <= S_GAP;
                        end
                    end else begin
                        rd_valid <= 1'b1;
                        rd_data  <= rx_byte;
                        rleft    <= rleft - 1'b1;
                        if (rleft > CNT_W'(1)) begin
                            state <= S_LOW;
                        end else begin
                            csn   <= 1'b1;
                            done  <= 1'b1;
                            gap2  <= 1'b0;
                            state <= S_GAP;
                        end
                    end
                end
                S_FEED: if (wr_valid) begin
                    wleft <= wleft - 1'b1;
                    phase <= P_PARAM;
                    state <= S_LOW;
                end
                S_GAP: if (tick) begin
                    if (gap2) begin
                        gap2  <= 1'b0;
                        phase <= P_CMD;
                        state <= S_IDLE;
                    end else begin
                        gap2 <= 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R8: a request is only taken with the panel deselected
    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> csn);
    // R1: clock parked low whenever the panel is deselected
    assert_sck_parked_R1: assert property (@(posedge clk) disable iff (rst)
        csn |-> !sck);
    // R9: done never lasts two cycles
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R3: parameters are pulled only inside a selected transfer
    assert_feed_selected_R3: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> !csn);
endmodule

// File: rtl/panel_cmd_spi9.sv
module panel_cmd_spi9
    import pspi_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_cmd,
    input  logic [CNT_W-1:0] req_wcnt,
    input  logic [CNT_W-1:0] req_rcnt,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             spi_csn,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    logic       run, tick, load, advance, sample, last, in_read;
    word_load_t load_word;
    logic [BYTE_BITS-1:0] rx_byte;

    pspi_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    pspi_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_word (load_word),
        .advance   (advance),
        .sample    (sample),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .last      (last),
        .rx_byte   (rx_byte)
    );

    pspi_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_cmd   (req_cmd),
        .req_wcnt  (req_wcnt),
        .req_rcnt  (req_rcnt),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .tick      (tick),
        .last      (last),
        .rx_byte   (rx_byte),
        .req_ready (req_ready),
        .wr_ready  (wr_ready),
        .run       (run),
        .load      (load),
        .load_word (load_word),
        .advance   (advance),
        .sample    (sample),
        .csn       (spi_csn),
        .sck       (spi_sck),
        .in_read   (in_read),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .done      (done)
    );

    // R6: data line quiet through the read phase
    assert_read_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (in_read && !spi_csn) |-> !spi_mosi);
    // R1: data line never moves while the clock is high
    assert_mosi_steady_R1: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> $stable(spi_mosi));
endmodule

// File: tb/test_panel_cmd_spi9.sv
`timescale 1ns/1ps
module test_panel_cmd_spi9;
    localparam int HALF_DIV = 2;
    localparam int CNT_W    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [7:0] req_cmd = '0;
    logic [CNT_W-1:0] req_wcnt = '0;
    logic [CNT_W-1:0] req_rcnt = '0;
    logic wr_valid = 1'b0;
    logic wr_ready;
    logic [7:0] wr_data = '0;
    logic rd_valid;
    logic [7:0] rd_data;
    logic done;
    logic spi_csn, spi_sck, spi_mosi;
    logic spi_miso = 1'b0;

    always #2.5 clk = ~clk;

    panel_cmd_spi9 #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) i_panel_cmd_spi9 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_wcnt(req_wcnt), .req_rcnt(req_rcnt),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails  = 0;

    bit        exp_bits[$];
    bit        cap_bits[$];
    bit        rbits[$];
    logic [7:0] rdq[$];
    logic [7:0] wbytes[16];
    logic [7:0] rbytes[16];
    int rise_cnt = 0;
    int nout     = 1000;
    int done_cnt = 0;
    int r1_viol = 0, r7_viol = 0, r8_viol = 0;
    int hi_run = 1000;
    logic prev_sck = 1'b0, prev_mosi = 1'b0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // behavioural panel: capture on rising SCK, present read bits after falling SCK
    always @(posedge spi_sck) if (!spi_csn) begin
        cap_bits.push_back(spi_mosi);
        rise_cnt++;
    end

    always @(negedge spi_sck) begin
        if (rise_cnt >= nout && (rise_cnt - nout) < rbits.size())
            spi_miso = rbits[rise_cnt - nout];
        else
            spi_miso = 1'b0;
    end

    always @(negedge clk) if (!rst) begin
        if (rd_valid) rdq.push_back(rd_data);
        if (done) done_cnt++;
        if (spi_csn && spi_sck) r1_viol++;
        if (spi_sck && prev_sck && spi_mosi !== prev_mosi) r1_viol++;
        if (req_ready && !spi_csn) r8_viol++;
        if (spi_csn) hi_run++;
        else begin
            if (hi_run > 0 && hi_run < 2*HALF_DIV) r7_viol++;
            hi_run = 0;
        end
        prev_sck  = spi_sck;
        prev_mosi = spi_mosi;
    end

    task automatic push_exp(input logic [8:0] w);
        for (int i = 8; i >= 0; i--) exp_bits.push_back(w[i]);
    endtask

    task automatic push_rd(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) rbits.push_back(b[i]);
    endtask

    task automatic run_xfer(input logic [7:0] cmd, input int nw, input int nr,
                            input bit lead, input int stall_at, input bit poke);
        int mism;
        int total;
        exp_bits.delete(); cap_bits.delete(); rbits.delete(); rdq.delete();
        done_cnt = 0;
        rise_cnt = 0;
        push_exp({1'b0, cmd});
        for (int p = 0; p < nw; p++) push_exp({1'b1, wbytes[p]});
        nout = 9 * (1 + nw);
        if (nr == 1) push_rd(rbytes[0]);
        else if (nr > 1) begin
            rbits.push_back(lead);
            for (int k = 0; k < nr; k++) push_rd(rbytes[k]);
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd;
        req_wcnt = CNT_W'(nw); req_rcnt = CNT_W'(nr);
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            req_valid = 1'b1; req_cmd = 8'h55; req_wcnt = '0; req_rcnt = '0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int p = 0; p < nw; p++) begin
            if (p == stall_at) repeat (20) @(negedge clk);
            wr_valid = 1'b1; wr_data = wbytes[p];
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
            wr_valid = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);

        total = nout + rbits.size();
        check(cap_bits.size() == total, "R7 bits framed by select", cap_bits.size(), total);
        if (cap_bits.size() == total) begin
            mism = 0;
            for (int i = 0; i < 9; i++) if (cap_bits[i] != exp_bits[i]) mism++;
            check(mism == 0, "R2 command word bits", mism, 0);
            if (nw > 0) begin
                mism = 0;
                for (int i = 9; i < nout; i++) if (cap_bits[i] != exp_bits[i]) mism++;
                check(mism == 0, "R3 parameter word bits", mism, 0);
            end
            if (nr > 0) begin
                mism = 0;
                for (int i = nout; i < total; i++) if (cap_bits[i] != 1'b0) mism++;
                check(mism == 0, "R6 mosi high during read", mism, 0);
            end
        end
        check(rdq.size() == nr, "R9 read byte count", rdq.size(), nr);
        if (rdq.size() == nr) begin
            for (int k = 0; k < nr; k++) begin
                if (nr == 1)
                    check(rdq[k] == rbytes[k], "R4 single read byte", rdq[k], rbytes[k]);
                else
                    check(rdq[k] == rbytes[k], "R5 multi read byte", rdq[k], rbytes[k]);
            end
        end
        check(done_cnt == 1, "R9 done pulses", done_cnt, 1);
        if (poke) begin
            total = cap_bits.size();
            repeat (40) @(negedge clk);
            check(cap_bits.size() == total, "R8 busy request ignored", cap_bits.size(), total);
            check(done_cnt == 1, "R8 no extra transfer", done_cnt, 1);
        end
        if (nw == 0 && nr == 0)
            check(rise_cnt == 9, "R10 bare command edges", rise_cnt, 9);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(spi_csn == 1'b1, "R7 reset deselected", spi_csn, 1);
        check(spi_sck == 1'b0, "R1 reset clock low", spi_sck, 0);
        check(req_ready == 1'b1, "R8 reset ready", req_ready, 1);
        check(done == 1'b0 && rd_valid == 1'b0, "R9 reset strobes low", done, 0);

        run_xfer(8'h29, 0, 0, 1'b0, -1, 1'b0);

        wbytes[0] = 8'h70;
        run_xfer(8'h3a, 1, 0, 1'b0, -1, 1'b0);

        wbytes[0] = 8'h02; wbytes[1] = 8'h81; wbytes[2] = 8'h00;
        wbytes[3] = 8'hC3; wbytes[4] = 8'h5A; wbytes[5] = 8'hFF;
        run_xfer(8'hc2, 6, 0, 1'b0, 3, 1'b0);

        rbytes[0] = 8'hA5;
        run_xfer(8'h0a, 0, 1, 1'b0, -1, 1'b0);

        rbytes[0] = 8'h45; rbytes[1] = 8'h83; rbytes[2] = 8'h1F;
        run_xfer(8'h04, 0, 3, 1'b1, -1, 1'b0);

        rbytes[0] = 8'h80; rbytes[1] = 8'h01;
        run_xfer(8'h0f, 0, 2, 1'b0, -1, 1'b0);

        wbytes[0] = 8'h3C;
        rbytes[0] = 8'hE7; rbytes[1] = 8'h18;
        run_xfer(8'hb0, 1, 2, 1'b1, 0, 1'b0);

        run_xfer(8'h28, 0, 0, 1'b0, -1, 1'b1);

        check(r1_viol == 0, "R1 mode 0 violations", r1_viol, 0);
        check(r7_viol == 0, "R7 short deselect gaps", r7_viol, 0);
        check(r8_viol == 0, "R8 ready while selected", r8_viol, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule